// File: doc/BRIEF.md
# Boot-Selectable Memory Remap Decoder

This block decides which memory target answers bus accesses that fall in the low code window starting at address zero. A two-bit mode register chooses one of four targets: main flash, system flash, the first external-memory bank, or the embedded 112 kB SRAM. The mode is loaded from two boot-strap pins while reset is held. After reset, software may rewrite it through a single configuration register.

For every valid bus address, the block registers exactly one outcome, one clock later:
- one remap select line, when the address is inside the window;
- a pass-through flag, when the address is outside the window;
- a grant to the external memory controller's register space;
- an error.

When the external-bank mode is active, only the first two external regions (128 MB) are reachable through the window. The external controller's control registers are also hidden. Accesses to either give an error and never reach the target.

Top module: `code_alias_decoder`

## Requirements
- R1: While reset is high, the mode loads from `boot_mode_i` on every clock edge, so after release it holds the value sampled at the last reset edge. All access outputs are low after reset.
- R2: Changes on `boot_mode_i` after reset release have no effect on the mode or on decoding.
- R3: A clock edge with `cfg_we` high loads the mode from `cfg_wdata[1:0]`, and bits 31:2 of the write are ignored. `cfg_rdata` returns the mode in bits 1:0 and zero in bits 31:2.
- R4: A valid access below 0x2000_0000 (a 512 MB window) asserts one bit of `tgt_sel` in the next cycle, chosen by the mode: mode 00 gives bit 0 (main flash), 01 gives bit 1 (system flash), 10 gives bit 2 (external bank) and 11 gives bit 3 (SRAM).
- R5: A valid access at or above 0x2000_0000 that is outside the external register space asserts `pass_o` in the next cycle, with `tgt_sel` zero.
- R6: In mode 10, a window access at offset 0x0800_0000 or above asserts `bus_err_o` with no select, so only the first two 64 MB regions are reachable.
- R7: In mode 10, a valid access to the external register space 0xA000_0000–0xA000_0FFF asserts `bus_err_o` and keeps `ext_reg_sel_o` low, so it has no write effect. In the other modes, such an access asserts `ext_reg_sel_o`.
- R8: A cycle with `bus_valid` low leaves all access outputs low in the next cycle.
- R9: An access in the same cycle as a configuration write is decoded with the mode that was in force before the write.
- R10: Each valid access produces exactly one of: a `tgt_sel` bit, `pass_o`, `ext_reg_sel_o` or `bus_err_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| boot_mode_i | input | 2 | Boot-strap mode pins, sampled during reset |
| cfg_we | input | 1 | Mode register write strobe |
| cfg_wdata | input | 32 | Mode register write data |
| cfg_rdata | output | 32 | Mode register read value |
| bus_valid | input | 1 | Access request valid |
| bus_addr | input | 32 | Access byte address |
| tgt_sel | output | 4 | Registered one-hot remap target select |
| pass_o | output | 1 | Registered flag: address outside the window, not remapped |
| ext_reg_sel_o | output | 1 | Registered grant to external controller registers |
| bus_err_o | output | 1 | Registered error response |

## Verification
On every cycle after reset, the assertions check the following:
- `tgt_sel` is one-hot and the four outcomes exclude one another.
- An idle cycle leaves the outputs low.
- The upper read bits stay zero.
- The mode moves only on a write.
- The mode after reset equals the boot pins.
- No register grant or out-of-range external select appears while the external mode is active.

Only the bench scenarios can show that each mode picks the right target, and that the window and register-space boundaries fall at the right addresses. The same holds for boot-pin changes after reset being ignored, and for a write in the same cycle as an access taking effect only for later accesses.

// File: rtl/remap_pkg.sv
package remap_pkg;
  typedef enum logic [1:0] {
    MAP_MAIN     = 2'b00,
    MAP_SYSFLASH = 2'b01,
    MAP_EXTBANK  = 2'b10,
    MAP_SRAM     = 2'b11
  } map_mode_e;

  localparam int NUM_TARGETS = 4;

  typedef struct packed {
    logic in_win;   // address inside the low alias window
    logic ext_ok;   // window offset inside the reachable external regions
    logic in_regs;  // address inside external controller register space
  } addr_class_t;
endpackage

// File: rtl/remap_mode_reg.sv
module remap_mode_reg
  import remap_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        boot_mode_i,
  input  logic              cfg_we,
  input  logic [DATA_W-1:0] cfg_wdata,
  output map_mode_e         mode_o,
  output logic [DATA_W-1:0] cfg_rdata
);
  localparam int PAD_W = DATA_W - 2;

  map_mode_e mode_q;
  logic      unused_hi;

  // Reload from strap pins on every reset edge; the last one wins.
  always_ff @(posedge clk) begin
    if (rst)         mode_q <= map_mode_e'(boot_mode_i);
    else if (cfg_we) mode_q <= map_mode_e'(cfg_wdata[1:0]);
  end

  assign unused_hi = ^cfg_wdata[DATA_W-1:2];
  assign mode_o    = mode_q;
  assign cfg_rdata = {{PAD_W{1'b0}}, mode_q};
endmodule

// File: rtl/remap_addr_class.sv
module remap_addr_class
  import remap_pkg::*;
#(
  parameter int                ADDR_W          = 32,
  parameter int                WIN_LOG2        = 29,
  parameter int                EXT_REGION_LOG2 = 26,
  parameter int                EXT_REGIONS     = 2,
  parameter int                EXT_REG_LOG2    = 12,
  parameter logic [ADDR_W-1:0] EXT_REG_BASE    = 32'hA000_0000
) (
  input  logic [ADDR_W-1:0] addr_i,
  output addr_class_t       cls_o
);
  localparam int HI_W = ADDR_W - WIN_LOG2;
  localparam logic [WIN_LOG2:0] EXT_SPAN =
    (WIN_LOG2+1)'(EXT_REGIONS) << EXT_REGION_LOG2;

  always_comb begin
    cls_o.in_win  = (addr_i[ADDR_W-1:WIN_LOG2] == {HI_W{1'b0}});
    cls_o.ext_ok  = ({1'b0, addr_i[WIN_LOG2-1:0]} < EXT_SPAN);
    cls_o.in_regs = (addr_i[ADDR_W-1:EXT_REG_LOG2] ==
                     EXT_REG_BASE[ADDR_W-1:EXT_REG_LOG2]);
  end
endmodule

// File: rtl/remap_out_stage.sv
module remap_out_stage
  import remap_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   valid_i,
  input  map_mode_e              mode_i,
  input  addr_class_t            cls_i,
  output logic [NUM_TARGETS-1:0] tgt_sel_o,
  output logic                   pass_o,
  output logic                   ext_reg_sel_o,
  output logic                   bus_err_o
);
  logic                   ext_mode;
  logic                   win_hit;
  logic                   win_err;
  logic                   reg_block;
  logic [NUM_TARGETS-1:0] sel_d;

  always_comb begin
    ext_mode  = (mode_i == MAP_EXTBANK);
    win_hit   = valid_i & cls_i.in_win;
    win_err   = win_hit & ext_mode & ~cls_i.ext_ok;
    reg_block = valid_i & cls_i.in_regs & ext_mode;
  end

  for (genvar t = 0; t < NUM_TARGETS; t++) begin : g_sel
    assign sel_d[t] = win_hit & ~win_err & (mode_i == map_mode_e'(t));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tgt_sel_o     <= '0;
      pass_o        <= 1'b0;
      ext_reg_sel_o <= 1'b0;
      bus_err_o     <= 1'b0;
    end else begin
      tgt_sel_o     <= sel_d;
      pass_o        <= valid_i & ~cls_i.in_win & ~cls_i.in_regs;
      ext_reg_sel_o <= valid_i & cls_i.in_regs & ~ext_mode;
      bus_err_o     <= win_err | reg_block;
    end
  end
endmodule

// File: rtl/code_alias_decoder.sv
module code_alias_decoder
  import remap_pkg::*;
#(
  parameter int                ADDR_W          = 32,
  parameter int                DATA_W          = 32,
  parameter int                WIN_LOG2        = 29,
  parameter int                EXT_REGION_LOG2 = 26,
  parameter int                EXT_REGIONS     = 2,
  parameter int                EXT_REG_LOG2    = 12,
  parameter logic [ADDR_W-1:0] EXT_REG_BASE    = 32'hA000_0000
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [1:0]             boot_mode_i,
  input  logic                   cfg_we,
  input  logic [DATA_W-1:0]      cfg_wdata,
  output logic [DATA_W-1:0]      cfg_rdata,
  input  logic                   bus_valid,
  input  logic [ADDR_W-1:0]      bus_addr,
  output logic [NUM_TARGETS-1:0] tgt_sel,
  output logic                   pass_o,
  output logic                   ext_reg_sel_o,
  output logic                   bus_err_o
);
  map_mode_e   mode;
  addr_class_t cls;

  remap_mode_reg #(.DATA_W(DATA_W)) u_mode (
    .clk         (clk),
    .rst         (rst),
    .boot_mode_i (boot_mode_i),
    .cfg_we      (cfg_we),
    .cfg_wdata   (cfg_wdata),
    .mode_o      (mode),
    .cfg_rdata   (cfg_rdata)
  );

  remap_addr_class #(
    .ADDR_W          (ADDR_W),
    .WIN_LOG2        (WIN_LOG2),
    .EXT_REGION_LOG2 (EXT_REGION_LOG2),
    .EXT_REGIONS     (EXT_REGIONS),
    .EXT_REG_LOG2    (EXT_REG_LOG2),
    .EXT_REG_BASE    (EXT_REG_BASE)
  ) u_class (
    .addr_i (bus_addr),
    .cls_o  (cls)
  );

  remap_out_stage u_out (
    .clk           (clk),
    .rst           (rst),
    .valid_i       (bus_valid),
    .mode_i        (mode),
    .cls_i         (cls),
    .tgt_sel_o     (tgt_sel),
    .pass_o        (pass_o),
    .ext_reg_sel_o (ext_reg_sel_o),
    .bus_err_o     (bus_err_o)
  );
endmodule

// File: rtl/code_alias_decoder_chk.sv
module code_alias_decoder_chk #(
  parameter int ADDR_W          = 32,
  parameter int DATA_W          = 32,
  parameter int WIN_LOG2        = 29,
  parameter int EXT_REGION_LOG2 = 26,
  parameter int EXT_REGIONS     = 2
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        boot_mode_i,
  input logic              cfg_we,
  input logic [DATA_W-1:0] cfg_rdata,
  input logic              bus_valid,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [3:0]        tgt_sel,
  input logic              pass_o,
  input logic              ext_reg_sel_o,
  input logic              bus_err_o
);
  localparam int REG_FIELD_W = WIN_LOG2 - EXT_REGION_LOG2;

  logic past_ok;
  logic unused_addr;

  always_ff @(posedge clk) begin
    if (rst) past_ok <= 1'b0;
    else     past_ok <= 1'b1;
  end

  assign unused_addr = ^{bus_addr[ADDR_W-1:WIN_LOG2], bus_addr[EXT_REGION_LOG2-1:0]};

  assert_boot_load_R1: assert property (@(posedge clk) disable iff (rst)
    $fell(rst) |-> cfg_rdata[1:0] == $past(boot_mode_i));

  assert_mode_hold_R2: assert property (@(posedge clk) disable iff (rst || !past_ok)
    !$past(cfg_we) |-> $stable(cfg_rdata));

  assert_upper_zero_R3: assert property (@(posedge clk) disable iff (rst)
    cfg_rdata[DATA_W-1:2] == '0);

  assert_onehot_sel_R4: assert property (@(posedge clk) disable iff (rst)
    $onehot0(tgt_sel));

  assert_ext_range_R6: assert property (@(posedge clk) disable iff (rst || !past_ok)
    tgt_sel[2] |-> $past(bus_addr[WIN_LOG2-1:EXT_REGION_LOG2]) < REG_FIELD_W'(EXT_REGIONS));

  assert_reg_gate_R7: assert property (@(posedge clk) disable iff (rst || !past_ok)
    ext_reg_sel_o |-> $past(cfg_rdata[1:0]) != 2'b10);

  assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
    !bus_valid |=> (tgt_sel == 4'b0) && !pass_o && !ext_reg_sel_o && !bus_err_o);

  assert_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $countones({|tgt_sel, pass_o, ext_reg_sel_o, bus_err_o}) <= 1);
endmodule

bind code_alias_decoder code_alias_decoder_chk #(
  .ADDR_W          (ADDR_W),
  .DATA_W          (DATA_W),
  .WIN_LOG2        (WIN_LOG2),
  .EXT_REGION_LOG2 (EXT_REGION_LOG2),
  .EXT_REGIONS     (EXT_REGIONS)
) u_chk (
  .clk           (clk),
  .rst           (rst),
  .boot_mode_i   (boot_mode_i),
  .cfg_we        (cfg_we),
  .cfg_rdata     (cfg_rdata),
  .bus_valid     (bus_valid),
  .bus_addr      (bus_addr),
  .tgt_sel       (tgt_sel),
  .pass_o        (pass_o),
  .ext_reg_sel_o (ext_reg_sel_o),
  .bus_err_o     (bus_err_o)
);

// File: tb/code_alias_decoder_bench.sv
module code_alias_decoder_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  boot_mode_i = 2'b11;
  logic        cfg_we = 1'b0;
  logic [31:0] cfg_wdata = '0;
  logic [31:0] cfg_rdata;
  logic        bus_valid = 1'b0;
  logic [31:0] bus_addr = '0;
  logic [3:0]  tgt_sel;
  logic        pass_o, ext_reg_sel_o, bus_err_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #10 clk = ~clk;

  code_alias_decoder u_code_alias_decoder (.*);

  // Result word layout: {tgt_sel[3:0], pass, reg_sel, err}
  typedef struct packed {
    logic [1:0]  mode;
    logic [31:0] addr;
    logic [6:0]  res;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VEC [NV] = '{
    '{2'b00, 32'h0000_1000, 7'b0001_000}, // R4 main flash
    '{2'b01, 32'h0000_0000, 7'b0010_000}, // R4 system flash
    '{2'b11, 32'h1FFF_FFFC, 7'b1000_000}, // R4 sram, top of window
    '{2'b10, 32'h0000_0040, 7'b0100_000}, // R4 external bank
    '{2'b10, 32'h07FF_FFFC, 7'b0100_000}, // R6 last reachable word
    '{2'b10, 32'h0800_0000, 7'b0000_001}, // R6 third region blocked
    '{2'b10, 32'h1FFF_FFFC, 7'b0000_001}, // R6 window top blocked
    '{2'b00, 32'h2000_0000, 7'b0000_100}, // R5 first address outside
    '{2'b10, 32'h2000_0000, 7'b0000_100}, // R5 outside in ext mode
    '{2'b10, 32'hA000_0010, 7'b0000_001}, // R7 registers hidden
    '{2'b01, 32'hA000_0FFC, 7'b0000_010}, // R7 registers reachable
    '{2'b00, 32'hA000_1000, 7'b0000_100}, // R5 just above registers
    '{2'b11, 32'h0800_0000, 7'b1000_000}  // R4 sram above 128 MB
  };

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", what, act, exp);
    end
  endtask

  function automatic logic [6:0] outs();
    return {tgt_sel, pass_o, ext_reg_sel_o, bus_err_o};
  endfunction

  task automatic set_mode(input logic [31:0] w);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = w;
    @(negedge clk); cfg_we = 1'b0;
  endtask

  task automatic access(input logic [31:0] a);
    @(negedge clk); bus_valid = 1'b1; bus_addr = a;
    @(negedge clk); bus_valid = 1'b0;
  endtask

  task automatic do_reset(input logic [1:0] boot);
    @(negedge clk); rst = 1'b1; boot_mode_i = boot;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    #(20 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired actual=hung expected=finish");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    do_reset(2'b11);
    check("R1 boot mode 11 loaded", cfg_rdata, 32'h3);
    check("R1 outputs idle after reset", {25'b0, outs()}, 32'h0);

    boot_mode_i = 2'b01;
    repeat (3) @(negedge clk);
    check("R2 boot pin change ignored", cfg_rdata, 32'h3);
    access(32'h0000_0100);
    check("R2 decode still sram", {25'b0, outs()}, {25'b0, 7'b1000_000});

    set_mode(32'hFFFF_FFF1);
    check("R3 upper write bits dropped", cfg_rdata, 32'h1);

    for (int i = 0; i < NV; i++) begin
      set_mode({30'b0, VEC[i].mode});
      access(VEC[i].addr);
      check($sformatf("vec %0d R4/R5/R6/R7", i), {25'b0, outs()}, {25'b0, VEC[i].res});
      check($sformatf("vec %0d R10 single outcome", i),
            $countones({|tgt_sel, pass_o, ext_reg_sel_o, bus_err_o}), 32'd1);
    end

    @(negedge clk); bus_valid = 1'b0; bus_addr = 32'h0000_0000;
    @(negedge clk);
    check("R8 no valid no outputs", {25'b0, outs()}, 32'h0);

    set_mode(32'h0);
    @(negedge clk);
    cfg_we = 1'b1; cfg_wdata = 32'h2; bus_valid = 1'b1; bus_addr = 32'h0000_0200;
    @(negedge clk);
    cfg_we = 1'b0; bus_valid = 1'b0;
    check("R9 same-cycle write uses old mode", {28'b0, tgt_sel}, 32'h1);
    check("R9 new mode visible", cfg_rdata, 32'h2);
    access(32'h0000_0200);
    check("R9 next access uses new mode", {28'b0, tgt_sel}, 32'h4);

    do_reset(2'b10);
    check("R1 boot mode 10 loaded", cfg_rdata, 32'h2);
    access(32'hA000_0000);
    check("R7 write blocked after boot to ext", {25'b0, outs()}, 32'h1);

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule